// File: doc/BRIEF.md
# Segment Selector Address Translator

This block turns a logical address, made of a 16-bit selector and a 32-bit offset, into a linear address. A table-select bit in the selector picks one of two descriptor table base inputs, global or local. The selector index, scaled by the 8-byte entry size, is added to that base to locate the descriptor. The block reads the descriptor as two 32-bit words through a synchronous memory read port. It then unpacks the segment base, the 20-bit limit and the class flag from those words.

For a code or data descriptor whose limit covers the offset, the block returns base plus offset. A system-class descriptor, such as a gate or a table or task-state entry, cannot be translated directly. The block marks such a result as system class. An offset beyond the limit of a code or data descriptor gives a one-cycle fault strobe in place of a result. The block takes one request at a time over a valid/ready handshake. The requestor privilege bits are returned unchanged, beside the result or the fault.

Top module: `seg_xlate`

## Requirements
- R1: The selector is split as index in bits [15:3], table select in bit 2 (0 picks `gdt_base`, 1 picks `ldt_base`) and privilege bits in [1:0]. The privilege bits come back on `res_rpl` with every result or fault.
- R2: The descriptor address is the chosen table base plus index times 8. The low word is read at that address, and the high word at that address plus 4, in the next cycle.
- R3: The memory port is synchronous. Data for a read asserted in one cycle is taken from `mem_rd_data` in the following cycle.
- R4: The segment base is assembled as {high[31:24], high[7:0], low[31:16]}.
- R5: The limit is {high[19:16], low[15:0]}. For a code/data descriptor, an offset strictly greater than the limit raises `fault_pulse` for exactly one cycle, and `res_valid` stays low.
- R6: When high-word bit 12 is 1 (code/data) and the offset is within the limit, `res_valid` pulses with `res_sys` = 0 and `res_lin` = base + offset modulo 2^32.
- R7: When high-word bit 12 is 0 (system class), `res_valid` pulses with `res_sys` = 1 and `res_lin` = 0. No fault is raised, even if the offset exceeds the limit.
- R8: `req_ready` is high only when the block is idle. After an accepting clock edge, `req_ready` is low until the result appears, four cycles later. `req_ready` is high again in the cycle the result appears.
- R9: During and right after reset, `req_ready` = 1 and `res_valid`, `fault_pulse` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_sel | input | 16 | Selector of the logical address |
| req_off | input | 32 | Offset of the logical address |
| gdt_base | input | 32 | Global descriptor table base |
| ldt_base | input | 32 | Local descriptor table base |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rd_data | input | 32 | Read data, one cycle after the strobe |
| res_valid | output | 1 | One-cycle result strobe |
| res_lin | output | 32 | Linear address (0 for system class) |
| res_sys | output | 1 | Descriptor is system class |
| res_rpl | output | 2 | Privilege bits of the selector |
| fault_pulse | output | 1 | One-cycle limit violation strobe |

## Verification
Two outcomes can arise from the same descriptor in one compute cycle: system-class classification and a limit overrun. The bench provokes this by giving system-class descriptors offsets both one past the limit and far beyond it. For these cases it expects a system-class result, with zero address and no fault, so classification takes priority over the limit check. It sweeps both tables over 16 indices with four offsets each, including the exact limit and the limit plus one. It also checks the latency and the privilege bits for every request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int DESC_WORD_W  = 32;
   localparam int DESC_LIM_W   = 20;
   localparam int CLASS_BIT    = 12;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_RD_LO   = 2'd1,
      ST_RD_HI   = 2'd2,
      ST_COMPUTE = 2'd3
   } xl_state_e;

   typedef struct packed {
      logic [DESC_WORD_W-1:0] base;
      logic [DESC_LIM_W-1:0]  limit;
      logic                   code_data;
   } seg_desc_t;

endpackage

// File: rtl/seg_sel_split.sv
module seg_sel_split #(
   parameter int SEL_W       = 16,
   parameter int ADDR_W      = 32,
   parameter int ENTRY_BYTES = 8
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] glob_base,
   input  logic [ADDR_W-1:0] loc_base,
   output logic [ADDR_W-1:0] entry_addr,
   output logic [1:0]        rpl
);
   localparam int IDX_LSB = 3;
   localparam int IDX_W   = SEL_W - IDX_LSB;
   localparam int SHIFT   = $clog2(ENTRY_BYTES);
   localparam int OFFS_W  = IDX_W + SHIFT;

   logic [IDX_W-1:0]  idx;
   logic              tbl_local;
   logic [ADDR_W-1:0] tbl_base;
   logic [OFFS_W-1:0] entry_offs;

   assign idx       = sel[SEL_W-1:IDX_LSB];
   assign tbl_local = sel[2];
   assign rpl       = sel[1:0];
   assign tbl_base  = tbl_local ? loc_base : glob_base;
   assign entry_offs = {idx, {SHIFT{1'b0}}};

   generate
      if (OFFS_W < ADDR_W) begin : g_ext
         assign entry_addr = tbl_base + {{(ADDR_W-OFFS_W){1'b0}}, entry_offs};
      end else begin : g_cut
         assign entry_addr = tbl_base + entry_offs[ADDR_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
   import seg_xlate_pkg::*;
(
   input  logic [DESC_WORD_W-1:0] w_lo,
   input  logic [DESC_WORD_W-1:0] w_hi,
   output seg_desc_t              desc
);
   logic unused_flag_bits;

   assign desc.base      = {w_hi[31:24], w_hi[7:0], w_lo[31:16]};
   assign desc.limit     = {w_hi[19:16], w_lo[15:0]};
   assign desc.code_data = w_hi[CLASS_BIT];

   assign unused_flag_bits = ^{w_hi[23:20], w_hi[15:13], w_hi[11:8]};

endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
   parameter int OFF_W   = 32,
   parameter int LIMIT_W = 20
) (
   input  logic [OFF_W-1:0]   off,
   input  logic [LIMIT_W-1:0] limit,
   output logic               over
);
   generate
      if (OFF_W > LIMIT_W) begin : g_wide_off
         assign over = off > {{(OFF_W-LIMIT_W){1'b0}}, limit};
      end else if (OFF_W == LIMIT_W) begin : g_same
         assign over = off > limit;
      end else begin : g_wide_lim
         assign over = {{(LIMIT_W-OFF_W){1'b0}}, off} > limit;
      end
   endgenerate

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int SEL_W       = 16,
   parameter int OFF_W       = 32,
   parameter int ADDR_W      = 32,
   parameter int LIMIT_W     = 20,
   parameter int ENTRY_BYTES = 8,
   parameter int WORD_BYTES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [15:0]       req_sel,
   input  logic [31:0]       req_off,
   input  logic [31:0]       gdt_base,
   input  logic [31:0]       ldt_base,
   output logic              mem_rd_en,
   output logic [31:0]       mem_rd_addr,
   input  logic [31:0]       mem_rd_data,
   output logic              res_valid,
   output logic [31:0]       res_lin,
   output logic              res_sys,
   output logic [1:0]        res_rpl,
   output logic              fault_pulse
);
   localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(WORD_BYTES);

   generate
      if (ADDR_W != DESC_WORD_W) begin : g_bad_addr
         $error("seg_xlate: ADDR_W must equal descriptor word width");
      end
      if (OFF_W != 32 || SEL_W != 16) begin : g_bad_port
         $error("seg_xlate: port widths are fixed at 16/32");
      end
      if (LIMIT_W != DESC_LIM_W) begin : g_bad_lim
         $error("seg_xlate: LIMIT_W must match descriptor limit width");
      end
      if (ENTRY_BYTES != 2 * WORD_BYTES) begin : g_bad_entry
         $error("seg_xlate: an entry must be two words");
      end
   endgenerate

   xl_state_e         state_q;
   logic [ADDR_W-1:0] entry_q;
   logic [OFF_W-1:0]  off_q;
   logic [1:0]        rpl_q;
   logic [31:0]       wlo_q;
   logic [ADDR_W-1:0] entry_addr;
   logic [1:0]        sel_rpl;
   seg_desc_t         desc;
   logic              over;

   seg_sel_split #(
      .SEL_W       (SEL_W),
      .ADDR_W      (ADDR_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_split (
      .sel        (req_sel),
      .glob_base  (gdt_base),
      .loc_base   (ldt_base),
      .entry_addr (entry_addr),
      .rpl        (sel_rpl)
   );

   seg_desc_unpack u_unpack (
      .w_lo (wlo_q),
      .w_hi (mem_rd_data),
      .desc (desc)
   );

   seg_limit_chk #(
      .OFF_W   (OFF_W),
      .LIMIT_W (LIMIT_W)
   ) u_lim (
      .off   (off_q),
      .limit (desc.limit),
      .over  (over)
   );

   assign req_ready   = (state_q == ST_IDLE);
   assign mem_rd_en   = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
   assign mem_rd_addr = (state_q == ST_RD_HI) ? (entry_q + HI_STEP) : entry_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         entry_q     <= '0;
         off_q       <= '0;
         rpl_q       <= '0;
         wlo_q       <= '0;
         res_valid   <= 1'b0;
         fault_pulse <= 1'b0;
         res_lin     <= '0;
         res_sys     <= 1'b0;
         res_rpl     <= '0;
      end else begin
         res_valid   <= 1'b0;
         fault_pulse <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  entry_q <= entry_addr;
                  off_q   <= req_off;
                  rpl_q   <= sel_rpl;
                  state_q <= ST_RD_LO;
               end
            end
            ST_RD_LO: begin
               state_q <= ST_RD_HI;
            end
            ST_RD_HI: begin
               wlo_q   <= mem_rd_data;
               state_q <= ST_COMPUTE;
            end
            ST_COMPUTE: begin
               res_rpl <= rpl_q;
               if (!desc.code_data) begin
                  res_valid <= 1'b1;
                  res_sys   <= 1'b1;
                  res_lin   <= '0;
               end else if (over) begin
                  fault_pulse <= 1'b1;
                  res_sys     <= 1'b0;
                  res_lin     <= '0;
               end else begin
                  res_valid <= 1'b1;
                  res_sys   <= 1'b0;
                  res_lin   <= desc.base + off_q;
               end
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic [15:0] req_sel,
   input logic        mem_rd_en,
   input logic [31:0] mem_rd_addr,
   input logic        res_valid,
   input logic [31:0] res_lin,
   input logic        res_sys,
   input logic [1:0]  res_rpl,
   input logic        fault_pulse
);
   AST_RESULT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && fault_pulse)); // R5

   AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |=> !fault_pulse); // R5

   AST_HI_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> (!mem_rd_en || mem_rd_addr == $past(mem_rd_addr) + 32'd4)); // R2

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R8

   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid || fault_pulse) |-> $past(req_valid && req_ready, 4)); // R8

   AST_SYS_ZERO_LIN: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_sys) |-> (res_lin == 32'd0)); // R7

   AST_RPL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid || fault_pulse) |-> (res_rpl == $past(req_sel[1:0], 4))); // R1

   AST_READY_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid || fault_pulse) |-> req_ready); // R8

endmodule

bind seg_xlate seg_xlate_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_sel     (req_sel),
   .mem_rd_en   (mem_rd_en),
   .mem_rd_addr (mem_rd_addr),
   .res_valid   (res_valid),
   .res_lin     (res_lin),
   .res_sys     (res_sys),
   .res_rpl     (res_rpl),
   .fault_pulse (fault_pulse)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [15:0] req_sel;
   logic [31:0] req_off;
   logic [31:0] gdt_base;
   logic [31:0] ldt_base;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic [31:0] mem_rd_data;
   logic        res_valid;
   logic [31:0] res_lin;
   logic        res_sys;
   logic [1:0]  res_rpl;
   logic        fault_pulse;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] mem [256];

   always #2 clk = ~clk;

   seg_xlate u_dut (
      .clk, .rst_n, .req_valid, .req_ready, .req_sel, .req_off,
      .gdt_base, .ldt_base, .mem_rd_en, .mem_rd_addr, .mem_rd_data,
      .res_valid, .res_lin, .res_sys, .res_rpl, .fault_pulse
   );

   always_ff @(posedge clk)
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:2]];

   function automatic logic [31:0] f_base(input int t, input int i);
      return {8'(i * 17 + t * 3 + 1), 8'(i + 64 + t), 16'(i * 4660 + t * 1911)};
   endfunction
   function automatic logic [19:0] f_limit(input int t, input int i);
      return 20'(i * 4951 + t * 136 + 5);
   endfunction
   function automatic logic f_code(input int i);
      return (i % 5) != 3;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_req(input int t, input int i, input logic [31:0] off,
                          input logic [1:0] rpl);
      int n;
      logic [31:0] b;
      logic [19:0] l;
      @(negedge clk);
      req_valid = 1'b1;
      req_sel   = {13'(i), 1'(t), rpl};
      req_off   = off;
      chk(req_ready == 1'b1, "R8 idle ready", 32'(req_ready), 32'd1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R8 busy", 32'(req_ready), 32'd0);
      n = 1;
      while (!(res_valid || fault_pulse) && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk(n == 4, "R8 latency / R3 read timing", 32'(n), 32'd4);
      chk(req_ready == 1'b1, "R8 ready with result", 32'(req_ready), 32'd1);
      chk(res_rpl == rpl, "R1 privilege bits", 32'(res_rpl), 32'(rpl));
      b = f_base(t, i);
      l = f_limit(t, i);
      if (!f_code(i)) begin
         chk(res_valid && !fault_pulse && res_sys, "R7 system class",
             {res_valid, fault_pulse, res_sys}, 32'b101);
         chk(res_lin == 32'd0, "R7 zero address", res_lin, 32'd0);
      end else if (off > {12'd0, l}) begin
         chk(fault_pulse && !res_valid, "R5 limit fault",
             {res_valid, fault_pulse}, 32'b01);
         @(negedge clk);
         chk(!fault_pulse, "R5 one-cycle fault", 32'(fault_pulse), 32'd0);
      end else begin
         chk(res_valid && !fault_pulse && !res_sys, "R6 code/data result",
             {res_valid, fault_pulse, res_sys}, 32'b100);
         chk(res_lin == b + off, "R6 R4 R2 linear address", res_lin, b + off);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      gdt_base  = 32'h0000_0100;
      ldt_base  = 32'h0000_0200;
      req_valid = 1'b0;
      req_sel   = '0;
      req_off   = '0;
      for (int w = 0; w < 256; w++) mem[w] = 32'hDEAD_0000 | 32'(w);
      for (int t = 0; t < 2; t++) begin
         for (int i = 0; i < 16; i++) begin
            logic [31:0] b;
            logic [19:0] l;
            int          wa;
            b  = f_base(t, i);
            l  = f_limit(t, i);
            wa = ((t == 1 ? 32'h200 : 32'h100) + i * 8) / 4;
            mem[wa]     = {b[15:0], l[15:0]};
            mem[wa + 1] = {b[31:24], 4'b0100, l[19:16], 1'b1, 2'b00,
                           f_code(i), 4'b1010, b[23:16]};
         end
      end
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(req_ready && !res_valid && !fault_pulse && !mem_rd_en, "R9 reset state",
          {req_ready, res_valid, fault_pulse, mem_rd_en}, 32'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !res_valid && !fault_pulse && !mem_rd_en, "R9 after reset",
          {req_ready, res_valid, fault_pulse, mem_rd_en}, 32'b1000);
      for (int t = 0; t < 2; t++) begin
         for (int i = 0; i < 16; i++) begin
            logic [19:0] l;
            l = f_limit(t, i);
            run_req(t, i, 32'd0, 2'(i));
            run_req(t, i, {12'd0, l}, 2'(i + 1));
            run_req(t, i, {12'd0, l} + 32'd1, 2'(i + 2));
            run_req(t, i, 32'hFFFF_FFF0 ^ 32'(i), 2'(i + 3));
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule